// File: doc/BRIEF.md
# Video Address Scroll Stepper

This block holds the 15-bit video memory address that a tile renderer walks while it draws a frame. The address is split into five fields: a coarse column, a coarse row, a horizontal screen-page select, a vertical screen-page select and a fine row inside an 8-line tile. The renderer's fetch timing issues short strobes that move the address one tile to the right, move it down one pixel line, or reload the horizontal part from a holding register at the start of a line. A full-width load port writes the whole register at once.

Each field wraps by its own rule. Stepping right past the last column flips the horizontal page. Stepping down past the last fine line advances the coarse row. The coarse row wraps after 30 rows, which gives 240 visible lines, and flips the vertical page when it does. A row value of 30 or 31 can only come from a load. From 31 the row returns to 0 and the page bit stays as it is. The output is the registered address, and every strobe takes effect at the next clock edge.

Top module: `vaddr_scroll_stepper`

## Requirements
- R1: During active-low reset, and after it is released, `addr_o` reads 0.
- R2: When `load_i` is high, the next `addr_o` equals `load_addr_i`. This takes priority over every strobe in the same cycle.
- R3: `inc_x_i` adds one to the coarse column in bits [4:0]. When the column goes from 31 to 0, bit 10 is inverted. The fields in bits [9:5] and [14:11] do not change.
- R4: `inc_y_i` adds one to the fine row in bits [14:12]. While the fine row is below 7, bits [11:5] are unchanged.
- R5: On `inc_y_i` with fine row 7, the fine row becomes 0 and the coarse row in bits [9:5] advances. A coarse row of 29 becomes 0 and bit 11 is inverted.
- R6: On `inc_y_i` with fine row 7 and coarse row 31, the coarse row becomes 0 and bit 11 is not changed. A coarse row of 30 becomes 31 with no change to bit 11.
- R7: `copy_h_i` loads bits [4:0] and bit 10 from `copy_src_i` and leaves the other bits unchanged. It overrides `inc_x_i` in the same cycle.
- R8: When `inc_x_i` and `inc_y_i` are both high, both steps are applied in the same cycle.
- R9: With no load and no strobe, `addr_o` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Write the whole address |
| load_addr_i | input | 15 | Value for a full write |
| copy_h_i | input | 1 | Reload the horizontal fields from `copy_src_i` |
| copy_src_i | input | 15 | Holding register; only bits [4:0] and bit 10 are used |
| inc_x_i | input | 1 | Step one tile to the right |
| inc_y_i | input | 1 | Step one pixel line down |
| addr_o | output | 15 | Current video address |

## Verification
The assertions in the design check these rules on every cycle:
- a full load lands in the next cycle;
- the address holds when there is no strobe;
- a horizontal copy takes only the column and horizontal page bits;
- a column wrap flips the horizontal page;
- a fine-row step leaves the coarse fields alone;
- the row-29 wrap and the row-31 wrap treat the vertical page bit differently.

Some behaviours only the bench scenarios can show:
- every one of the 32768 start values, followed by a vertical step;
- both steps applied in the same cycle;
- the priority of a load and a copy over the step strobes;
- long random strobe streams, in which wraps follow one another.

// File: rtl/vaddr_pkg.sv
package vaddr_pkg;
  typedef struct packed {
    logic load;
    logic copy_h;
    logic inc_x;
    logic inc_y;
  } step_req_t;
endpackage

// File: rtl/vaddr_h_step.sv
module vaddr_h_step #(
  parameter int COARSE_W = 5
) (
  input  logic [COARSE_W-1:0] col_i,
  input  logic                page_i,
  input  logic                inc_i,
  output logic [COARSE_W-1:0] col_o,
  output logic                page_o
);
  always_comb begin
    col_o  = col_i;
    page_o = page_i;
    if (inc_i) begin
      col_o = col_i + COARSE_W'(1);
      if (&col_i) page_o = ~page_i;
    end
  end
endmodule

// File: rtl/vaddr_v_step.sv
module vaddr_v_step #(
  parameter int FINE_W   = 3,
  parameter int COARSE_W = 5,
  parameter int ROWS     = 30
) (
  input  logic [FINE_W-1:0]   fine_i,
  input  logic [COARSE_W-1:0] row_i,
  input  logic                page_i,
  input  logic                inc_i,
  output logic [FINE_W-1:0]   fine_o,
  output logic [COARSE_W-1:0] row_o,
  output logic                page_o
);
  localparam logic [COARSE_W-1:0] ROW_LAST = COARSE_W'(ROWS - 1);

  always_comb begin
    fine_o = fine_i;
    row_o  = row_i;
    page_o = page_i;
    if (inc_i) begin
      fine_o = fine_i + FINE_W'(1);
      if (&fine_i) begin
        if (row_i == ROW_LAST) begin
          row_o  = '0;
          page_o = ~page_i;
        end else if (&row_i) begin
          // out-of-frame row left by a load: wrap quietly
          row_o = '0;
        end else begin
          row_o = row_i + COARSE_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/vaddr_scroll_stepper.sv
module vaddr_scroll_stepper #(
  parameter int FINE_W   = 3,
  parameter int COARSE_W = 5,
  parameter int ROWS     = 30,
  localparam int CY_LO   = COARSE_W,
  localparam int NH_BIT  = 2 * COARSE_W,
  localparam int NV_BIT  = NH_BIT + 1,
  localparam int FY_LO   = NV_BIT + 1,
  localparam int ADDR_W  = FY_LO + FINE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_addr_i,
  input  logic              copy_h_i,
  input  logic [ADDR_W-1:0] copy_src_i,
  input  logic              inc_x_i,
  input  logic              inc_y_i,
  output logic [ADDR_W-1:0] addr_o
);
  import vaddr_pkg::*;

  localparam logic [COARSE_W-1:0] COL_MAX  = '1;
  localparam logic [FINE_W-1:0]   FINE_MAX = '1;
  localparam logic [COARSE_W-1:0] ROW_LAST = COARSE_W'(ROWS - 1);
  localparam bit ROWS_SHORT = (ROWS < (1 << COARSE_W));

  logic [ADDR_W-1:0] addr_q, addr_d;
  step_req_t req;

  logic [COARSE_W-1:0] col_q, row_q, col_n, row_n;
  logic [FINE_W-1:0]   fine_q, fine_n;
  logic                nh_q, nv_q, nh_n, nv_n;

  logic unused_src;
  assign unused_src = ^{copy_src_i[ADDR_W-1:NV_BIT], copy_src_i[NH_BIT-1:CY_LO]};

  assign req    = '{load: load_i, copy_h: copy_h_i, inc_x: inc_x_i, inc_y: inc_y_i};
  assign col_q  = addr_q[COARSE_W-1:0];
  assign row_q  = addr_q[CY_LO +: COARSE_W];
  assign nh_q   = addr_q[NH_BIT];
  assign nv_q   = addr_q[NV_BIT];
  assign fine_q = addr_q[FY_LO +: FINE_W];

  vaddr_h_step #(.COARSE_W(COARSE_W)) u_h_step (
    .col_i (col_q),
    .page_i(nh_q),
    .inc_i (req.inc_x & ~req.copy_h),
    .col_o (col_n),
    .page_o(nh_n)
  );

  vaddr_v_step #(.FINE_W(FINE_W), .COARSE_W(COARSE_W), .ROWS(ROWS)) u_v_step (
    .fine_i(fine_q),
    .row_i (row_q),
    .page_i(nv_q),
    .inc_i (req.inc_y),
    .fine_o(fine_n),
    .row_o (row_n),
    .page_o(nv_n)
  );

  always_comb begin
    if (req.load) begin
      addr_d = load_addr_i;
    end else if (req.copy_h) begin
      addr_d = {fine_n, nv_n, copy_src_i[NH_BIT], row_n, copy_src_i[COARSE_W-1:0]};
    end else begin
      addr_d = {fine_n, nv_n, nh_n, row_n, col_n};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) addr_q <= '0;
    else         addr_q <= addr_d;
  end

  assign addr_o = addr_q;

  a_r2_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> addr_o == $past(load_addr_i));

  a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !copy_h_i && !inc_x_i && !inc_y_i) |=> $stable(addr_o));

  a_r7_copy_fields: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && copy_h_i) |=>
      (addr_o[COARSE_W-1:0] == $past(copy_src_i[COARSE_W-1:0])) &&
      (addr_o[NH_BIT] == $past(copy_src_i[NH_BIT])));

  a_r3_col_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !copy_h_i && inc_x_i && addr_o[COARSE_W-1:0] == COL_MAX) |=>
      (addr_o[COARSE_W-1:0] == '0) && (addr_o[NH_BIT] != $past(addr_o[NH_BIT])));

  a_r4_fine_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && inc_y_i && addr_o[FY_LO +: FINE_W] != FINE_MAX) |=>
      $stable(addr_o[NV_BIT:CY_LO]) || $past(copy_h_i) || $past(inc_x_i));

  a_r5_row_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && inc_y_i && addr_o[FY_LO +: FINE_W] == FINE_MAX &&
     addr_o[CY_LO +: COARSE_W] == ROW_LAST) |=>
      (addr_o[CY_LO +: COARSE_W] == '0) && (addr_o[NV_BIT] != $past(addr_o[NV_BIT])));

  a_r6_no_toggle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ROWS_SHORT && !load_i && inc_y_i && addr_o[FY_LO +: FINE_W] == FINE_MAX &&
     addr_o[CY_LO +: COARSE_W] == COL_MAX) |=>
      (addr_o[CY_LO +: COARSE_W] == '0) && $stable(addr_o[NV_BIT]));
endmodule

// File: tb/vaddr_scroll_stepper_bench.sv
module vaddr_scroll_stepper_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load = 1'b0, copy_h = 1'b0, inc_x = 1'b0, inc_y = 1'b0;
  logic [14:0] load_addr = '0, copy_src = '0;
  logic [14:0] addr;

  int    exp_addr = 0;
  int    vectors = 0, fails = 0, cycles = 0;
  bit    done = 1'b0;
  string phase = "R1 reset";

  always #10 clk = ~clk;

  vaddr_scroll_stepper u_vaddr_scroll_stepper (
    .clk_i(clk), .rst_ni(rst_n), .load_i(load), .load_addr_i(load_addr),
    .copy_h_i(copy_h), .copy_src_i(copy_src), .inc_x_i(inc_x), .inc_y_i(inc_y),
    .addr_o(addr)
  );

  // reference: plain masks and adds on integers
  function automatic int model_next(int a, bit ld, int ldv, bit cp, int src, bit ix, bit iy);
    int n, cy;
    if (ld) return ldv;
    n = a;
    if (iy) begin
      if ((n & 'h7000) != 'h7000) n = n + 'h1000;
      else begin
        n  = n & ~'h7000;
        cy = (n >> 5) & 31;
        if (cy == 29) begin cy = 0; n = n ^ 'h800; end
        else if (cy == 31) cy = 0;
        else cy = cy + 1;
        n = (n & ~'h3e0) | (cy << 5);
      end
    end
    if (cp) n = (n & ~'h41f) | (src & 'h41f);
    else if (ix) begin
      if ((n & 31) == 31) n = (n & ~31) ^ 'h400;
      else n = n + 1;
    end
    return n & 'h7fff;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) exp_addr <= 0;
    else exp_addr <= model_next(exp_addr, load, int'(load_addr), copy_h,
                                int'(copy_src), inc_x, inc_y);
  end

  always @(negedge clk) begin
    if (!done) begin
      vectors++;
      if (int'(addr) != exp_addr) begin
        fails++;
        $display("FAIL %s: addr_o=%h expected=%h", phase, addr, exp_addr[14:0]);
      end
    end
  end

  task automatic finish_run();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 180000 && !done) begin
      fails++;
      $display("FAIL watchdog: cycles=%0d expected<180000", cycles);
      finish_run();
    end
  end

  task automatic drive(bit ld, int ldv, bit cp, int src, bit ix, bit iy);
    @(negedge clk);
    load = ld; load_addr = ldv[14:0]; copy_h = cp; copy_src = src[14:0];
    inc_x = ix; inc_y = iy;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    phase = "R1 reset value";
    repeat (2) drive(0, 0, 0, 0, 0, 0);

    phase = "R2 load priority";
    drive(1, 'h5a5a, 1, 'h7fff, 1, 1);
    phase = "R9 hold";
    repeat (3) drive(0, 0, 0, 0, 0, 0);

    phase = "R4/R5/R6 y sweep";
    for (int v = 0; v < 32768; v++) begin
      drive(1, v, 0, 0, 0, 0);
      drive(0, 0, 0, 0, 0, 1);
    end

    phase = "R3 x sweep";
    for (int v = 0; v < 32768; v += 3) begin
      drive(1, v, 0, 0, 0, 0);
      drive(0, 0, 0, 0, 1, 0);
    end

    phase = "R8 x+y together";
    for (int v = 0; v < 32768; v += 7) begin
      drive(1, v, 0, 0, 0, 0);
      drive(0, 0, 0, 0, 1, 1);
    end

    phase = "R7 horizontal copy";
    for (int v = 0; v < 32768; v += 17) begin
      drive(1, v, 0, 0, 0, 0);
      drive(0, 0, 1, int'($urandom_range(0, 32767)), v[0], v[1]);
    end

    phase = "R6 row 30 and 31 corner";
    drive(1, 'h73c0, 0, 0, 0, 0);
    drive(0, 0, 0, 0, 0, 1);
    drive(0, 0, 0, 0, 0, 0);
    drive(1, 'h77e0, 0, 0, 0, 0);
    drive(0, 0, 0, 0, 0, 1);
    drive(0, 0, 0, 0, 0, 0);

    phase = "R3/R5/R7/R8 random stream";
    for (int i = 0; i < 6000; i++) begin
      drive(($urandom_range(0, 99) == 0), int'($urandom_range(0, 32767)),
            ($urandom_range(0, 15) == 0), int'($urandom_range(0, 32767)),
            $urandom_range(0, 1) == 1, $urandom_range(0, 2) == 0);
    end

    phase = "R9 final hold";
    repeat (4) drive(0, 0, 0, 0, 0, 0);
    @(negedge clk);
    #1;
    finish_run();
  end
endmodule